// File: doc/BRIEF.md
# Host Controller Command and Interrupt Status Registers

This block holds two 32-bit registers of a USB host controller: a command register and an interrupt status register. Software reaches them through a byte-lane register bus. The controller core reaches them through single-cycle event pulses and a frame-number MSB level. The command register carries three kinds of bit:
- a reset request that clears itself,
- two list-filled flags that either side may set and only hardware clears,
- an ownership request that software both sets and clears.

It also holds a 2-bit overrun counter. The interrupt status register collects event bits that software clears by writing 1, and an interrupt-pending output reports any bit that is set.

The register bus has no back-pressure. A write (`bus_we` high) is taken on the clock edge of the cycle it is presented in, one write per cycle. Read data is a combinational function of `bus_addr` and the register state, so there is no read strobe. Event inputs are one-cycle pulses and may arrive in any cycle, including the cycle of a bus write to the same bit.

Top module: `hc_cmdint_regs`

## Requirements
- R1: After reset every bit of both registers reads 0 and `irq_pending` is 0. The command register is at byte offset 08h and the interrupt status register at 0Ch. Reads of any other offset return 0.
- R2: Command bit 0 (reset request, `hc_reset_req`) is set by a write of 1 and cleared by an `ev_reset_done` pulse. A write of 0 has no effect. If the set and the clear come in the same cycle, the set wins.
- R3: Command bit 1 (control list filled) and bit 2 (bulk list filled) are set by a write of 1 or by `ev_ctrl_fill`/`ev_bulk_fill`. They are cleared only by `ev_ctrl_head`/`ev_bulk_head`, and a set in the same cycle wins over that clear. Writing 0 has no effect.
- R4: Command bit 3 (ownership request, `own_change_req`) takes the written value. Every write of 1 to it also sets interrupt status bit 30 (ownership change). Clearing the request leaves that status bit set.
- R5: A write changes only the bytes whose `bus_be` lane is 1. Lane n covers bits 8n+7..8n.
- R6: The overrun count sits in command bits 17:16. It increments by one on each `ev_sched_ovr` pulse, even if the status bit is already 1, and wraps from 3 to 0. Bus writes never change it.
- R7: In the interrupt status register, writing 1 to a bit clears it and writing 0 leaves it unchanged. Bits 31, 29..7 and 4 always read 0.
- R8: Interrupt status bits are set by pulses: bit 0 by `ev_sched_ovr`, bit 1 by `ev_done_head`, bit 2 by `ev_sof`, bit 3 by `ev_resume` and bit 6 by `ev_rh_change`. A set in the same cycle as a write-1 clear wins.
- R9: Interrupt status bit 4 (unrecoverable error) reads 0 at all times, including after a write of 1.
- R10: Interrupt status bit 5 is set whenever `frame_msb` differs from its value in the previous cycle, for a change in either direction. The previous value counts as 0 right after reset.
- R11: `irq_pending` is 1 exactly when at least one implemented interrupt status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the register word |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| ev_sof | input | 1 | Start-of-frame pulse |
| ev_done_head | input | 1 | Done-head writeback pulse |
| ev_resume | input | 1 | Resume detected pulse |
| ev_sched_ovr | input | 1 | Scheduling overrun pulse |
| ev_rh_change | input | 1 | Root hub status change pulse |
| ev_ctrl_fill | input | 1 | Controller sets the control list flag |
| ev_bulk_fill | input | 1 | Controller sets the bulk list flag |
| ev_ctrl_head | input | 1 | Processing of the control list head begins |
| ev_bulk_head | input | 1 | Processing of the bulk list head begins |
| ev_reset_done | input | 1 | Controller reset finished |
| frame_msb | input | 1 | Bit 15 of the frame number |
| hc_reset_req | output | 1 | Reset request bit |
| ctrl_list_filled | output | 1 | Control list filled flag |
| bulk_list_filled | output | 1 | Bulk list filled flag |
| own_change_req | output | 1 | Ownership request bit |
| sched_ovr_cnt | output | 2 | Overrun count |
| irq_pending | output | 1 | OR of interrupt status bits |

## Verification
Every write, event pulse and `frame_msb` change takes effect on the first clock edge after it is presented. It is visible on the flag outputs, on `irq_pending` and on `bus_rdata` during the cycle after that edge, and `bus_rdata` needs no further read latency. The driver applies each stimulus at a falling edge. In the next cycle it sets `bus_addr` to the register it expects to read and queues the expected value. The monitor compares the queued value at the following rising edge, before that edge updates any register, so each check sees exactly the state the stimulus produced. Same-cycle set/clear collisions are driven as one stimulus so that their priority is checked.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  // command register bit positions
  localparam int CMD_RST_B  = 0;
  localparam int CMD_CTRL_B = 1;
  localparam int CMD_BULK_B = 2;
  localparam int CMD_OWN_B  = 3;
  localparam int CMD_CNT_LSB = 16;

  // interrupt status bit positions
  localparam int IS_SO_B   = 0;
  localparam int IS_WDH_B  = 1;
  localparam int IS_SF_B   = 2;
  localparam int IS_RD_B   = 3;
  localparam int IS_UE_B   = 4;
  localparam int IS_FNO_B  = 5;
  localparam int IS_RHSC_B = 6;
  localparam int IS_OC_B   = 30;

  // bits that exist as storage in the interrupt status register
  localparam logic [31:0] IS_IMPL_MASK =
    (32'd1 << IS_SO_B) | (32'd1 << IS_WDH_B) | (32'd1 << IS_SF_B) |
    (32'd1 << IS_RD_B) | (32'd1 << IS_FNO_B) | (32'd1 << IS_RHSC_B) |
    (32'd1 << IS_OC_B);
endpackage

// File: rtl/hcr_w1c_bit.sv
module hcr_w1c_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // a hardware set in the same cycle as a clear keeps the bit
  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/hcr_toggle_det.sv
module hcr_toggle_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic tog_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign tog_o = rst_n & (lvl_i ^ prev_q);
endmodule

// File: rtl/hcr_cmd_reg.sv
module hcr_cmd_reg #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lane0_we,
  input  logic [3:0]       lane0_wd,
  input  logic             ev_reset_done,
  input  logic             ev_ctrl_fill,
  input  logic             ev_bulk_fill,
  input  logic             ev_ctrl_head,
  input  logic             ev_bulk_head,
  input  logic             ev_sched_ovr,
  output logic             rst_q,
  output logic             ctrl_q,
  output logic             bulk_q,
  output logic             own_q,
  output logic             own_set_o,
  output logic [CNT_W-1:0] cnt_q
);
  import hcr_pkg::*;

  logic wr_rst, wr_ctrl, wr_bulk;

  assign wr_rst   = lane0_we & lane0_wd[CMD_RST_B];
  assign wr_ctrl  = lane0_we & lane0_wd[CMD_CTRL_B];
  assign wr_bulk  = lane0_we & lane0_wd[CMD_BULK_B];
  assign own_set_o = lane0_we & lane0_wd[CMD_OWN_B];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_q  <= 1'b0;
      ctrl_q <= 1'b0;
      bulk_q <= 1'b0;
      own_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (wr_rst)             rst_q <= 1'b1;
      else if (ev_reset_done) rst_q <= 1'b0;

      if (wr_ctrl || ev_ctrl_fill) ctrl_q <= 1'b1;
      else if (ev_ctrl_head)       ctrl_q <= 1'b0;

      if (wr_bulk || ev_bulk_fill) bulk_q <= 1'b1;
      else if (ev_bulk_head)       bulk_q <= 1'b0;

      if (lane0_we) own_q <= lane0_wd[CMD_OWN_B];

      if (ev_sched_ovr) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hcr_int_reg.sv
module hcr_int_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_v,
  input  logic [DATA_W-1:0] clr_v,
  output logic [DATA_W-1:0] stat_q
);
  import hcr_pkg::*;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i < 32 && IS_IMPL_MASK[i % 32]) begin : g_impl
      hcr_w1c_bit u_bit (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_v[i]),
        .clr_i (clr_v[i]),
        .q_o   (stat_q[i])
      );
    end else begin : g_zero
      assign stat_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/hc_cmdint_regs.sv
module hc_cmdint_regs #(
  parameter int              ADDR_W  = 8,
  parameter int              DATA_W  = 32,
  parameter int              CNT_W   = 2,
  parameter logic [ADDR_W-1:0] CMD_OFS = 8'h08,
  parameter logic [ADDR_W-1:0] INT_OFS = 8'h0C
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                ev_sof,
  input  logic                ev_done_head,
  input  logic                ev_resume,
  input  logic                ev_sched_ovr,
  input  logic                ev_rh_change,
  input  logic                ev_ctrl_fill,
  input  logic                ev_bulk_fill,
  input  logic                ev_ctrl_head,
  input  logic                ev_bulk_head,
  input  logic                ev_reset_done,
  input  logic                frame_msb,
  output logic                hc_reset_req,
  output logic                ctrl_list_filled,
  output logic                bulk_list_filled,
  output logic                own_change_req,
  output logic [CNT_W-1:0]    sched_ovr_cnt,
  output logic                irq_pending
);
  import hcr_pkg::*;

  localparam int BE_W = DATA_W / 8;

  logic              cmd_hit, int_hit;
  logic              own_set;
  logic              fno_tog;
  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] is_set, is_clr, is_q;
  logic [DATA_W-1:0] cmd_rd;

  assign cmd_hit = (bus_addr == CMD_OFS);
  assign int_hit = (bus_addr == INT_OFS);

  // expand byte enables to a bit mask
  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign lane_mask[8*b +: 8] = {8{bus_be[b]}};
  end

  hcr_cmd_reg #(.CNT_W(CNT_W)) u_cmd (
    .clk           (clk),
    .rst_n         (rst_n),
    .lane0_we      (bus_we & cmd_hit & bus_be[0]),
    .lane0_wd      (bus_wdata[3:0]),
    .ev_reset_done (ev_reset_done),
    .ev_ctrl_fill  (ev_ctrl_fill),
    .ev_bulk_fill  (ev_bulk_fill),
    .ev_ctrl_head  (ev_ctrl_head),
    .ev_bulk_head  (ev_bulk_head),
    .ev_sched_ovr  (ev_sched_ovr),
    .rst_q         (hc_reset_req),
    .ctrl_q        (ctrl_list_filled),
    .bulk_q        (bulk_list_filled),
    .own_q         (own_change_req),
    .own_set_o     (own_set),
    .cnt_q         (sched_ovr_cnt)
  );

  hcr_toggle_det u_fno (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (frame_msb),
    .tog_o (fno_tog)
  );

  always_comb begin
    is_set            = '0;
    is_set[IS_SO_B]   = ev_sched_ovr;
    is_set[IS_WDH_B]  = ev_done_head;
    is_set[IS_SF_B]   = ev_sof;
    is_set[IS_RD_B]   = ev_resume;
    is_set[IS_FNO_B]  = fno_tog;
    is_set[IS_RHSC_B] = ev_rh_change;
    is_set[IS_OC_B]   = own_set;
  end

  assign is_clr = {DATA_W{bus_we & int_hit}} & lane_mask & bus_wdata;

  hcr_int_reg #(.DATA_W(DATA_W)) u_int (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_v  (is_set),
    .clr_v  (is_clr),
    .stat_q (is_q)
  );

  assign irq_pending = |is_q;

  always_comb begin
    cmd_rd                          = '0;
    cmd_rd[CMD_RST_B]               = hc_reset_req;
    cmd_rd[CMD_CTRL_B]              = ctrl_list_filled;
    cmd_rd[CMD_BULK_B]              = bulk_list_filled;
    cmd_rd[CMD_OWN_B]               = own_change_req;
    cmd_rd[CMD_CNT_LSB +: CNT_W]    = sched_ovr_cnt;
  end

  always_comb begin
    if (cmd_hit)      bus_rdata = cmd_rd;
    else if (int_hit) bus_rdata = is_q;
    else              bus_rdata = '0;
  end
endmodule

// File: rtl/hcr_chk.sv
module hcr_chk #(
  parameter int              ADDR_W  = 8,
  parameter int              DATA_W  = 32,
  parameter int              CNT_W   = 2,
  parameter logic [ADDR_W-1:0] CMD_OFS = 8'h08,
  parameter logic [ADDR_W-1:0] INT_OFS = 8'h0C
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W/8-1:0] bus_be,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                ev_sof,
  input logic                ev_sched_ovr,
  input logic                ev_ctrl_fill,
  input logic                ev_bulk_fill,
  input logic                ev_bulk_head,
  input logic                ev_reset_done,
  input logic                hc_reset_req,
  input logic                ctrl_list_filled,
  input logic                bulk_list_filled,
  input logic                own_change_req,
  input logic [CNT_W-1:0]    sched_ovr_cnt,
  input logic                irq_pending
);
  logic cmd_wr0;
  assign cmd_wr0 = bus_we && (bus_addr == CMD_OFS) && bus_be[0];

  // R2
  hc_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_reset_done && !(cmd_wr0 && bus_wdata[0])) |=> !hc_reset_req);

  // R3
  ctrl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ctrl_fill |=> ctrl_list_filled);

  // R3
  bulk_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bulk_head && !ev_bulk_fill && !(cmd_wr0 && bus_wdata[2])) |=> !bulk_list_filled);

  // R4
  own_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr0 && bus_wdata[3]) |=> (own_change_req && irq_pending));

  // R6
  ovr_cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sched_ovr |=> (sched_ovr_cnt == $past(sched_ovr_cnt) + 1'b1));

  // R6
  ovr_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_sched_ovr |=> $stable(sched_ovr_cnt));

  // R8
  sof_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sof |=> irq_pending);

  // R9
  ue_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == INT_OFS) |-> !bus_rdata[4]);

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr == INT_OFS) && (bus_rdata == '0)) |-> !irq_pending);
endmodule

bind hc_cmdint_regs hcr_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
  .CMD_OFS(CMD_OFS), .INT_OFS(INT_OFS)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .bus_we           (bus_we),
  .bus_addr         (bus_addr),
  .bus_be           (bus_be),
  .bus_wdata        (bus_wdata),
  .bus_rdata        (bus_rdata),
  .ev_sof           (ev_sof),
  .ev_sched_ovr     (ev_sched_ovr),
  .ev_ctrl_fill     (ev_ctrl_fill),
  .ev_bulk_fill     (ev_bulk_fill),
  .ev_bulk_head     (ev_bulk_head),
  .ev_reset_done    (ev_reset_done),
  .hc_reset_req     (hc_reset_req),
  .ctrl_list_filled (ctrl_list_filled),
  .bulk_list_filled (bulk_list_filled),
  .own_change_req   (own_change_req),
  .sched_ovr_cnt    (sched_ovr_cnt),
  .irq_pending      (irq_pending)
);

// File: tb/hc_cmdint_regs_tb.sv
module hc_cmdint_regs_tb;
  localparam logic [7:0] CMD = 8'h08;
  localparam logic [7:0] INT = 8'h0C;
  // event vector bit order used by the driver
  localparam int E_SOF = 0, E_DONE = 1, E_RES = 2, E_OVR = 3, E_RH = 4;
  localparam int E_CFIL = 5, E_BFIL = 6, E_CHD = 7, E_BHD = 8, E_RDN = 9;
  localparam int SEL_RD = 0, SEL_IRQ = 1;

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [9:0]  ev = '0;
  logic        frame_msb = 1'b0;
  logic        hc_reset_req, ctrl_list_filled, bulk_list_filled, own_change_req;
  logic [1:0]  sched_ovr_cnt;
  logic        irq_pending;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  item_t sb_q[$];

  always #10 clk = ~clk;

  hc_cmdint_regs u_dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .bus_we           (bus_we),
    .bus_addr         (bus_addr),
    .bus_be           (bus_be),
    .bus_wdata        (bus_wdata),
    .bus_rdata        (bus_rdata),
    .ev_sof           (ev[E_SOF]),
    .ev_done_head     (ev[E_DONE]),
    .ev_resume        (ev[E_RES]),
    .ev_sched_ovr     (ev[E_OVR]),
    .ev_rh_change     (ev[E_RH]),
    .ev_ctrl_fill     (ev[E_CFIL]),
    .ev_bulk_fill     (ev[E_BFIL]),
    .ev_ctrl_head     (ev[E_CHD]),
    .ev_bulk_head     (ev[E_BHD]),
    .ev_reset_done    (ev[E_RDN]),
    .frame_msb        (frame_msb),
    .hc_reset_req     (hc_reset_req),
    .ctrl_list_filled (ctrl_list_filled),
    .bulk_list_filled (bulk_list_filled),
    .own_change_req   (own_change_req),
    .sched_ovr_cnt    (sched_ovr_cnt),
    .irq_pending      (irq_pending)
  );

  // driver: one stimulus cycle
  task automatic drive(input logic we, input logic [7:0] a, input logic [3:0] be,
                       input logic [31:0] wd, input logic [9:0] e);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd; ev = e;
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] wd);
    drive(1'b1, a, be, wd, '0);
  endtask

  task automatic pulse(input logic [9:0] e);
    drive(1'b0, 8'h00, 4'h0, '0, e);
  endtask

  // driver: idle cycle that selects a read address and queues the expectation
  task automatic expect_val(input int sel, input logic [7:0] a,
                            input logic [31:0] v, input string tag);
    item_t it;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0; bus_wdata = '0; ev = '0; bus_addr = a;
    it.sel = sel; it.exp = v; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compare before this edge updates any register
  always @(posedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      act = (it.sel == SEL_IRQ) ? {31'd0, irq_pending} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state and unmapped offset
    expect_val(SEL_RD, CMD, 32'h0, "R1 cmd reset");
    expect_val(SEL_RD, INT, 32'h0, "R1 int reset");
    expect_val(SEL_IRQ, INT, 32'h0, "R1 irq reset");
    expect_val(SEL_RD, 8'h10, 32'h0, "R1 unmapped");

    // R2 R3 R4 software sets
    wr(CMD, 4'b0001, 32'h0000_000F);
    expect_val(SEL_RD, CMD, 32'h0000_000F, "R2 R3 R4 cmd set");
    expect_val(SEL_RD, INT, 32'h4000_0000, "R4 ownership echo");
    expect_val(SEL_IRQ, INT, 32'h1, "R11 irq on echo");

    pulse(10'd1 << E_RDN);
    expect_val(SEL_RD, CMD, 32'h0000_000E, "R2 reset done");
    pulse(10'd1 << E_CHD);
    expect_val(SEL_RD, CMD, 32'h0000_000C, "R3 ctrl head clear");
    pulse((10'd1 << E_BHD) | (10'd1 << E_BFIL));
    expect_val(SEL_RD, CMD, 32'h0000_000C, "R3 bulk set wins");

    wr(CMD, 4'b0001, 32'h0);
    expect_val(SEL_RD, CMD, 32'h0000_0004, "R3 R4 write zero");
    expect_val(SEL_RD, INT, 32'h4000_0000, "R4 status kept");

    // R5 lane enables
    wr(CMD, 4'b1110, 32'h0000_000B);
    expect_val(SEL_RD, CMD, 32'h0000_0004, "R5 cmd lane0 off");
    wr(INT, 4'b0111, 32'h4000_0000);
    expect_val(SEL_RD, INT, 32'h4000_0000, "R5 int lane3 off");
    wr(INT, 4'b1000, 32'h0);
    expect_val(SEL_RD, INT, 32'h4000_0000, "R7 zero write");
    wr(INT, 4'b1000, 32'h4000_0000);
    expect_val(SEL_RD, INT, 32'h0, "R7 w1c");
    expect_val(SEL_IRQ, INT, 32'h0, "R11 irq clear");

    // R6 counter
    pulse(10'd1 << E_OVR);
    expect_val(SEL_RD, CMD, 32'h0001_0004, "R6 count 1");
    expect_val(SEL_RD, INT, 32'h0000_0001, "R8 overrun bit");
    for (int i = 0; i < 3; i++) pulse(10'd1 << E_OVR);
    expect_val(SEL_RD, CMD, 32'h0000_0004, "R6 wrap");
    wr(CMD, 4'b0100, 32'h00FF_0000);
    expect_val(SEL_RD, CMD, 32'h0000_0004, "R6 write ignored");

    wr(INT, 4'b1111, 32'hFFFF_FFFF);
    expect_val(SEL_RD, INT, 32'h0, "R7 clear all");

    // R8 set beats clear
    drive(1'b1, INT, 4'b0001, 32'h0000_0004, 10'd1 << E_SOF);
    expect_val(SEL_RD, INT, 32'h0000_0004, "R8 set wins");
    pulse((10'd1 << E_DONE) | (10'd1 << E_RES) | (10'd1 << E_RH));
    expect_val(SEL_RD, INT, 32'h0000_004E, "R8 event bits");

    // R9 unrecoverable error
    wr(INT, 4'b0001, 32'h0000_0010);
    expect_val(SEL_RD, INT, 32'h0000_004E, "R9 ue write");
    wr(INT, 4'b1111, 32'hFFFF_FFFF);
    expect_val(SEL_RD, INT, 32'h0, "R9 R7 cleared");
    expect_val(SEL_IRQ, INT, 32'h0, "R11 irq none");

    // R10 frame msb toggles
    @(negedge clk); frame_msb = 1'b1;
    expect_val(SEL_RD, INT, 32'h0000_0020, "R10 rise");
    wr(INT, 4'b0001, 32'h0000_0020);
    expect_val(SEL_RD, INT, 32'h0, "R10 steady");
    @(negedge clk); frame_msb = 1'b0;
    expect_val(SEL_RD, INT, 32'h0000_0020, "R10 fall");
    expect_val(SEL_IRQ, INT, 32'h1, "R11 irq on fno");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule